// File: doc/BRIEF.md
# Loop Bandwidth and Damping Selector

This block picks the loop-filter bandwidth index and the damping index that a digital PLL's loop filter applies. A processor writes a small register set through a plain write strobe: an automatic-mode enable, an acquisition bandwidth code, a locked bandwidth code and a damping code. A lock indication from the phase detector then decides which bandwidth code is in force.

With automatic mode on, the wide acquisition bandwidth is used while the loop is unlocked, and the locked bandwidth is used once lock is reported. With automatic mode off, the locked bandwidth is used in both states. A status flag shows whether the acquisition setting is currently in force. One parameter builds the block either for the main loop, which has ten bandwidth steps, or for a secondary loop, which has only three steps. In both builds any code beyond the last legal step saturates to that step.

The block has no data stream, so every pin is a plain level or strobe and there is no back-pressure. The outputs are registered and change only on a clock edge.

Top module: `bwsel_ctrl`

## Requirements
- R1: `acq_active_o` is 1 exactly when the acquisition bandwidth is in force, which means automatic mode is on and lock is low. Otherwise it is 0.
- R2: With automatic mode on and `lock_i` low, `bw_idx_o` carries the saturated acquisition code.
- R3: With automatic mode on and `lock_i` high, `bw_idx_o` carries the saturated locked code.
- R4: With automatic mode off, `bw_idx_o` carries the saturated locked code whatever the level of `lock_i`.
- R5: In the main-loop build (SEC_LOOP=0), 4-bit bandwidth codes 0 to 9 pass through unchanged, and codes 10 to 15 give 9.
- R6: In the secondary-loop build (SEC_LOOP=1), the codes are 0=18 Hz, 1=35 Hz and 2=70 Hz, and codes 3 to 15 give 2.
- R7: The 3-bit damping code selects 0=1.2, 1=2.5, 2=5, 3=10 or 4=20. Codes 5 to 7 give 4. `damp_idx_o` carries the saturated code in both builds.
- R8: A rise or fall of `lock_i` changes the outputs on the first clock edge that samples it, and not before that edge. A write with `cfg_we` high is reflected on the outputs at the edge that captures it.
- R9: Reset clears automatic mode and all codes. While reset is held, `bw_idx_o`=0, `damp_idx_o`=0 and `acq_active_o`=0.
- R10: While `cfg_we` is low, changes on the `cfg_*` data pins have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the register set |
| cfg_auto_en | input | 1 | Automatic bandwidth mode enable |
| cfg_acq_bw | input | 4 | Acquisition bandwidth code |
| cfg_lock_bw | input | 4 | Locked bandwidth code |
| cfg_damp | input | 3 | Damping code |
| lock_i | input | 1 | Lock indication from the phase detector |
| bw_idx_o | output | 4 | Bandwidth index in force |
| damp_idx_o | output | 3 | Damping index in force |
| acq_active_o | output | 1 | 1 while the acquisition setting is in force |

## Verification
A stored register that is corrupted or a saturation limit that is wrong shows at the next clock edge. It appears as a wrong `bw_idx_o` or `damp_idx_o` for a specific code, so the bench writes every combination of mode, both bandwidth codes and damping code, in both builds at once. A wrong selection decision shows as a mismatch between `acq_active_o` and the bandwidth actually driven within one cycle of a change on `lock_i`. Each written combination is therefore observed with lock low and then with lock high. A register that loads without the strobe shows one edge after the data pins change, and the bench checks that edge.

// File: rtl/bwsel_pkg.sv
package bwsel_pkg;

  typedef enum logic {
    SEL_LOCKED = 1'b0,
    SEL_ACQ    = 1'b1
  } bw_sel_e;

  // Saturate a code to the last legal step index.
  function automatic int unsigned sat_index(input int unsigned code,
                                            input int unsigned last);
    return (code > last) ? last : code;
  endfunction

endpackage

// File: rtl/bwsel_cfg_regs.sv
module bwsel_cfg_regs #(
  parameter int unsigned BW_W  = 4,
  parameter int unsigned DMP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             auto_d,
  input  logic [BW_W-1:0]  acq_d,
  input  logic [BW_W-1:0]  lck_d,
  input  logic [DMP_W-1:0] dmp_d,
  output logic             auto_o,
  output logic [BW_W-1:0]  acq_o,
  output logic [BW_W-1:0]  lck_o,
  output logic [DMP_W-1:0] dmp_o
);

  logic             auto_q;
  logic [BW_W-1:0]  acq_q;
  logic [BW_W-1:0]  lck_q;
  logic [DMP_W-1:0] dmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q <= 1'b0;
      acq_q  <= '0;
      lck_q  <= '0;
      dmp_q  <= '0;
    end else if (we) begin
      auto_q <= auto_d;
      acq_q  <= acq_d;
      lck_q  <= lck_d;
      dmp_q  <= dmp_d;
    end
  end

  // Write data bypasses the registers so that a write and the output stage
  // land on the same edge.
  always_comb begin
    auto_o = we ? auto_d : auto_q;
    acq_o  = we ? acq_d  : acq_q;
    lck_o  = we ? lck_d  : lck_q;
    dmp_o  = we ? dmp_d  : dmp_q;
  end

  // R10: stored settings move only on a strobed write
  p_hold_no_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(auto_q) && $stable(acq_q) && $stable(lck_q) && $stable(dmp_q)));

endmodule

// File: rtl/bwsel_sat.sv
module bwsel_sat #(
  parameter int unsigned W    = 4,
  parameter int unsigned LAST = 9
) (
  input  logic [W-1:0] code_i,
  output logic [W-1:0] idx_o
);
  import bwsel_pkg::*;

  localparam int unsigned CODE_MAX = (1 << W) - 1;

  generate
    if (LAST >= CODE_MAX) begin : g_pass
      assign idx_o = code_i;
    end else begin : g_sat
      assign idx_o = W'(sat_index(32'(code_i), LAST));
    end
  endgenerate

endmodule

// File: rtl/bwsel_ctrl.sv
module bwsel_ctrl #(
  parameter int unsigned MAIN_STEPS = 10,
  parameter int unsigned SEC_STEPS  = 3,
  parameter int unsigned DAMP_STEPS = 5,
  parameter bit          SEC_LOOP   = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_auto_en,
  input  logic [3:0] cfg_acq_bw,
  input  logic [3:0] cfg_lock_bw,
  input  logic [2:0] cfg_damp,
  input  logic       lock_i,
  output logic [3:0] bw_idx_o,
  output logic [2:0] damp_idx_o,
  output logic       acq_active_o
);
  import bwsel_pkg::*;

  localparam int unsigned BW_W    = $clog2(MAIN_STEPS);
  localparam int unsigned DMP_W   = $clog2(DAMP_STEPS);
  localparam int unsigned BW_LAST = SEC_LOOP ? (SEC_STEPS - 1) : (MAIN_STEPS - 1);
  localparam int unsigned DMP_LAST = DAMP_STEPS - 1;
  localparam logic [BW_W-1:0]  BW_LAST_C  = BW_W'(BW_LAST);
  localparam logic [DMP_W-1:0] DMP_LAST_C = DMP_W'(DMP_LAST);

  logic             auto_eff;
  logic [BW_W-1:0]  acq_eff, lck_eff, acq_c, lck_c;
  logic [DMP_W-1:0] dmp_eff, dmp_c;

  bwsel_cfg_regs #(.BW_W(BW_W), .DMP_W(DMP_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .auto_d(cfg_auto_en), .acq_d(cfg_acq_bw), .lck_d(cfg_lock_bw), .dmp_d(cfg_damp),
    .auto_o(auto_eff), .acq_o(acq_eff), .lck_o(lck_eff), .dmp_o(dmp_eff)
  );

  bwsel_sat #(.W(BW_W),  .LAST(BW_LAST))  sat_acq_i (.code_i(acq_eff), .idx_o(acq_c));
  bwsel_sat #(.W(BW_W),  .LAST(BW_LAST))  sat_lck_i (.code_i(lck_eff), .idx_o(lck_c));
  bwsel_sat #(.W(DMP_W), .LAST(DMP_LAST)) sat_dmp_i (.code_i(dmp_eff), .idx_o(dmp_c));

  bw_sel_e         sel_n, sel_q;
  logic [BW_W-1:0] bw_n, bw_q;
  logic [DMP_W-1:0] dmp_q;

  always_comb begin
    sel_n = (auto_eff && !lock_i) ? SEL_ACQ : SEL_LOCKED;
    bw_n  = (sel_n == SEL_ACQ) ? acq_c : lck_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_LOCKED;
      bw_q  <= '0;
      dmp_q <= '0;
    end else begin
      sel_q <= sel_n;
      bw_q  <= bw_n;
      dmp_q <= dmp_c;
    end
  end

  assign bw_idx_o     = bw_q;
  assign damp_idx_o   = dmp_q;
  assign acq_active_o = (sel_q == SEL_ACQ);

  // R2: automatic and unlocked -> acquisition code, flag high
  p_auto_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_eff && !lock_i) |=> (acq_active_o && bw_idx_o == $past(acq_c)));

  // R3: automatic and locked -> locked code, flag low
  p_auto_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_eff && lock_i) |=> (!acq_active_o && bw_idx_o == $past(lck_c)));

  // R4: fixed mode always uses the locked code
  p_fixed_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_eff |=> (!acq_active_o && bw_idx_o == $past(lck_c)));

  // R5 / R6: driven bandwidth never beyond the last step of this build
  p_bw_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bw_idx_o <= BW_LAST_C);

  // R7: damping index stays within the five values and follows the code
  p_damp_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (damp_idx_o <= DMP_LAST_C && damp_idx_o == $past(dmp_c)));

endmodule

// File: tb/bwsel_ctrl_tb_top.sv
module bwsel_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic       cfg_auto_en;
  logic [3:0] cfg_acq_bw, cfg_lock_bw;
  logic [2:0] cfg_damp;
  logic       lock_i;
  logic [3:0] bw_m, bw_s;
  logic [2:0] dmp_m, dmp_s;
  logic       act_m, act_s;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  bwsel_ctrl #(.SEC_LOOP(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_auto_en(cfg_auto_en),
    .cfg_acq_bw(cfg_acq_bw), .cfg_lock_bw(cfg_lock_bw), .cfg_damp(cfg_damp),
    .lock_i(lock_i), .bw_idx_o(bw_m), .damp_idx_o(dmp_m), .acq_active_o(act_m)
  );

  bwsel_ctrl #(.SEC_LOOP(1'b1)) dut_sec_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_auto_en(cfg_auto_en),
    .cfg_acq_bw(cfg_acq_bw), .cfg_lock_bw(cfg_lock_bw), .cfg_damp(cfg_damp),
    .lock_i(lock_i), .bw_idx_o(bw_s), .damp_idx_o(dmp_s), .acq_active_o(act_s)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int code, input int last);
    return (code > last) ? last : code;
  endfunction

  // Compare both builds against the arithmetic model.
  task automatic expect_all(input string req, input int a, input int l,
                            input int acq, input int lk, input int d);
    int use_acq;
    use_acq = (a == 1 && l == 0) ? 1 : 0;
    check({req, " R1 flag main"}, int'(act_m), use_acq);
    check({req, " R1 flag sec"},  int'(act_s), use_acq);
    check({req, " R2/R3/R4/R5 bw main"}, int'(bw_m),
          use_acq ? sat(acq, 9) : sat(lk, 9));
    check({req, " R6 bw sec"}, int'(bw_s),
          use_acq ? sat(acq, 2) : sat(lk, 2));
    check({req, " R7 damp main"}, int'(dmp_m), sat(d, 4));
    check({req, " R7 damp sec"},  int'(dmp_s), sat(d, 4));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; cfg_we = 1'b0; cfg_auto_en = 1'b0;
    cfg_acq_bw = 4'd7; cfg_lock_bw = 4'd7; cfg_damp = 3'd3; lock_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    expect_all("R9 reset", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    expect_all("R9 after release", 0, 0, 0, 0, 0);

    for (int a = 0; a < 2; a++) begin
      for (int acq = 0; acq < 16; acq++) begin
        for (int lk = 0; lk < 16; lk++) begin
          for (int d = 0; d < 8; d++) begin
            // strobed write with lock low
            cfg_we = 1'b1; cfg_auto_en = a[0];
            cfg_acq_bw = acq[3:0]; cfg_lock_bw = lk[3:0]; cfg_damp = d[2:0];
            lock_i = 1'b0;
            @(posedge clk); @(negedge clk);
            expect_all("R8 write", a, 0, acq, lk, d);
            // raise lock: no change before the edge, change at it
            cfg_we = 1'b0; lock_i = 1'b1;
            #1;
            expect_all("R8 lock not before edge", a, 0, acq, lk, d);
            @(posedge clk); @(negedge clk);
            expect_all("R8 lock rise", a, 1, acq, lk, d);
            // data pins move without strobe: must be ignored
            cfg_auto_en = ~a[0]; cfg_acq_bw = ~acq[3:0];
            cfg_lock_bw = ~lk[3:0]; cfg_damp = ~d[2:0];
            @(posedge clk); @(negedge clk);
            expect_all("R10 no strobe", a, 1, acq, lk, d);
            // drop lock: revert on first edge
            if (d == 7) begin
              lock_i = 1'b0;
              @(posedge clk); @(negedge clk);
              expect_all("R8 lock fall", a, 0, acq, lk, d);
            end
          end
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule